// File: doc/BRIEF.md
# Byte-Wide Parallel Slave Port

This block lets an external processor exchange single bytes with an on-chip CPU over a shared 8-bit data bus. The external side uses three active-low strobes: chip select, read and write. A read with the chip selected puts the CPU's outgoing byte onto the bus. A write with the chip selected captures the bus into an incoming byte register. The external data bus is split into an input, an output and an output enable, so the pad ring builds the tri-state driver.

The internal side sees one control/status byte. It holds a 4-bit direction field, the slave-mode enable and three handshake flags:
- incoming-full, set by an external write and cleared by a CPU read of the incoming byte;
- outgoing-full, set by a CPU write of the outgoing byte and cleared by an external read;
- overrun, set when an external write lands on a byte the CPU has not yet read.

The strobes pass through two-flop synchronisers before their rising edges are detected. The bus output enable is decoded directly from the raw strobes, so the external reader sees data without clock latency.

Top module: `par_slave_port`

## Requirements
- R1: After reset the control byte reads 8'b0000_1111 (direction field all ones, mode and all flags clear) and the bus output enable is low.
- R2: While the mode bit (control bit 4) is clear, external strobes have no effect: the output enable stays low, no flag changes and the incoming byte keeps its value.
- R3: The output enable is high exactly when the mode bit is set and both read and chip select are low, with no clock delay; while it is high the bus output carries the last byte written by the CPU to the outgoing register.
- R4: With mode set, a write strobe with chip select low captures the external bus into the incoming byte, which the CPU sees on its read data port.
- R5: With mode set, the rising edge of the write strobe while chip select is low sets incoming-full (control bit 7); a write with chip select high changes nothing.
- R6: A CPU read pulse on the incoming byte clears incoming-full.
- R7: An external write that completes while incoming-full is already set sets overrun (control bit 5). A control write with bit 5 at 0 clears overrun; a control write with bit 5 at 1 leaves it unchanged.
- R8: A CPU write of the outgoing byte sets outgoing-full (control bit 6). The rising edge of the read strobe with chip select low and mode set clears it.
- R9: Control writes load bits 4 to 0 directly; bits 7 and 6 are read-only, and writes to them are ignored.
- R10: Each strobe passes through two synchroniser flops. A flag change caused by a strobe release becomes visible at the third rising clock edge after the release, and not at the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_cs_n | input | 1 | External chip select, active low |
| ext_rd_n | input | 1 | External read strobe, active low |
| ext_wr_n | input | 1 | External write strobe, active low |
| ext_data_i | input | 8 | External bus, value seen at the pins |
| ext_data_o | output | 8 | External bus, value to drive |
| ext_data_oe | output | 1 | Drive enable for the external bus |
| cpu_ctrl_we | input | 1 | CPU write strobe for the control byte |
| cpu_ctrl_wdata | input | 8 | CPU write data for the control byte |
| cpu_ctrl_rdata | output | 8 | Control byte: {in_full, out_full, overrun, mode, dir[3:0]} |
| cpu_in_re | input | 1 | CPU read pulse on the incoming byte |
| cpu_in_data | output | 8 | Incoming byte |
| cpu_out_we | input | 1 | CPU write strobe for the outgoing byte |
| cpu_out_wdata | input | 8 | CPU write data for the outgoing byte |

## Verification
The checker watches several conditions on every cycle:
- the bus is driven only when the mode bit is set and read and chip select are low;
- overrun only rises when incoming-full was already set;
- incoming-full only falls after a CPU read pulse;
- outgoing-full follows every CPU outgoing write;
- the incoming byte never moves while the mode bit is clear.

Other properties need whole external transactions, and only the bench scenarios show them:
- the captured byte value;
- that a deselected strobe is ignored;
- the write-0-to-clear rule for overrun;
- the three-edge latency through the synchronisers.

// File: rtl/pslv_pkg.sv
package pslv_pkg;
    localparam int CTRL_W   = 8;
    localparam int DIR_W    = 4;
    localparam int BIT_MODE = 4;
    localparam int BIT_OVF  = 5;
    localparam int BIT_OBF  = 6;
    localparam int BIT_IBF  = 7;

    typedef struct packed {
        logic [7:0]       in_byte;
        logic [7:0]       out_byte;
        logic [DIR_W-1:0] dir;
        logic             mode;
        logic             ibf;
        logic             obf;
        logic             ovf;
    } pslv_state_t;

    localparam pslv_state_t PSLV_RESET = '{
        in_byte:  8'h00,
        out_byte: 8'h00,
        dir:      {DIR_W{1'b1}},
        mode:     1'b0,
        ibf:      1'b0,
        obf:      1'b0,
        ovf:      1'b0
    };
endpackage

// File: rtl/pslv_sync.sv
module pslv_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '1;
        else        stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '1;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pslv_edge.sv
module pslv_edge #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb prev_d = level_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/pslv_regs.sv
module pslv_regs
    import pslv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_lvl,
    input  logic        wr_lvl,
    input  logic        rd_rise,
    input  logic        wr_rise,
    input  logic [7:0]  bus_in,
    input  logic        ctrl_we,
    input  logic [7:0]  ctrl_wdata,
    input  logic        in_re,
    input  logic        out_we,
    input  logic [7:0]  out_wdata,
    output pslv_state_t state_o
);
    pslv_state_t st_d, st_q;
    logic        sel_lvl, wr_done, rd_done;

    always_comb begin
        sel_lvl = st_q.mode & ~cs_lvl;
        wr_done = sel_lvl & wr_rise;
        rd_done = sel_lvl & rd_rise;
        st_d    = st_q;

        // capture while the write strobe is held
        if (sel_lvl && !wr_lvl) st_d.in_byte = bus_in;

        if (ctrl_we) begin
            st_d.dir  = ctrl_wdata[DIR_W-1:0];
            st_d.mode = ctrl_wdata[BIT_MODE];
            st_d.ovf  = st_q.ovf & ctrl_wdata[BIT_OVF];
        end
        if (wr_done && st_q.ibf) st_d.ovf = 1'b1;

        if (in_re)   st_d.ibf = 1'b0;
        if (wr_done) st_d.ibf = 1'b1;

        if (rd_done) st_d.obf = 1'b0;
        if (out_we) begin
            st_d.obf      = 1'b1;
            st_d.out_byte = out_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PSLV_RESET;
        else        st_q <= st_d;
    end

    assign state_o = st_q;
endmodule

// File: rtl/par_slave_port.sv
module par_slave_port
    import pslv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_cs_n,
    input  logic       ext_rd_n,
    input  logic       ext_wr_n,
    input  logic [7:0] ext_data_i,
    output logic [7:0] ext_data_o,
    output logic       ext_data_oe,
    input  logic       cpu_ctrl_we,
    input  logic [7:0] cpu_ctrl_wdata,
    output logic [7:0] cpu_ctrl_rdata,
    input  logic       cpu_in_re,
    output logic [7:0] cpu_in_data,
    input  logic       cpu_out_we,
    input  logic [7:0] cpu_out_wdata
);
    localparam int NSTB = 3;  // {cs, wr, rd}

    logic [NSTB-1:0] stb_sync, stb_rise;
    pslv_state_t     st;

    pslv_sync #(.WIDTH(NSTB), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ext_cs_n, ext_wr_n, ext_rd_n}),
        .sync_o  (stb_sync)
    );

    pslv_edge #(.WIDTH(NSTB)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (stb_sync),
        .rise_o  (stb_rise)
    );

    pslv_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_lvl     (stb_sync[2]),
        .wr_lvl     (stb_sync[1]),
        .rd_rise    (stb_rise[0]),
        .wr_rise    (stb_rise[1]),
        .bus_in     (ext_data_i),
        .ctrl_we    (cpu_ctrl_we),
        .ctrl_wdata (cpu_ctrl_wdata),
        .in_re      (cpu_in_re),
        .out_we     (cpu_out_we),
        .out_wdata  (cpu_out_wdata),
        .state_o    (st)
    );

    assign ext_data_oe    = st.mode & ~ext_rd_n & ~ext_cs_n;
    assign ext_data_o     = st.out_byte;
    assign cpu_in_data    = st.in_byte;
    assign cpu_ctrl_rdata = {st.ibf, st.obf, st.ovf, st.mode, st.dir};
endmodule

// File: rtl/par_slave_port_chk.sv
module par_slave_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ext_cs_n,
    input logic       ext_rd_n,
    input logic       ext_data_oe,
    input logic [7:0] cpu_ctrl_rdata,
    input logic       cpu_in_re,
    input logic [7:0] cpu_in_data,
    input logic       cpu_out_we
);
    // R3: drive only with mode set and the raw strobes asserted
    a_r3_oe_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ext_data_oe |-> (cpu_ctrl_rdata[4] && !ext_cs_n && !ext_rd_n));

    // R2: no drive while the mode bit is clear
    a_r2_mode_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ctrl_rdata[4] |-> !ext_data_oe);

    // R2: the incoming byte only moves while the mode bit is set
    a_r2_in_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cpu_in_data) |-> $past(cpu_ctrl_rdata[4]));

    // R7: overrun only rises when incoming-full was already set
    a_r7_ovf_needs_ibf: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_ctrl_rdata[5]) |-> $past(cpu_ctrl_rdata[7]));

    // R6: incoming-full only falls after a CPU read pulse
    a_r6_ibf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_ctrl_rdata[7]) |-> $past(cpu_in_re));

    // R8: a CPU outgoing write always leaves outgoing-full set
    a_r8_obf_set: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_out_we |=> cpu_ctrl_rdata[6]);
endmodule

bind par_slave_port par_slave_port_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ext_cs_n       (ext_cs_n),
    .ext_rd_n       (ext_rd_n),
    .ext_data_oe    (ext_data_oe),
    .cpu_ctrl_rdata (cpu_ctrl_rdata),
    .cpu_in_re      (cpu_in_re),
    .cpu_in_data    (cpu_in_data),
    .cpu_out_we     (cpu_out_we)
);

// File: tb/par_slave_port_bench.sv
module par_slave_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_cs_n = 1'b1, ext_rd_n = 1'b1, ext_wr_n = 1'b1;
    logic [7:0] ext_data_i = 8'h00;
    logic [7:0] ext_data_o;
    logic       ext_data_oe;
    logic       cpu_ctrl_we = 1'b0;
    logic [7:0] cpu_ctrl_wdata = 8'h00;
    logic [7:0] cpu_ctrl_rdata;
    logic       cpu_in_re = 1'b0;
    logic [7:0] cpu_in_data;
    logic       cpu_out_we = 1'b0;
    logic [7:0] cpu_out_wdata = 8'h00;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // reference model
    logic [7:0] m_in = 8'h00, m_out = 8'h00;
    logic [3:0] m_dir = 4'hF;
    logic       m_mode = 0, m_ibf = 0, m_obf = 0, m_ovf = 0;

    always #5 clk = ~clk;

    par_slave_port u_par_slave_port (.*);

    function automatic logic [7:0] exp_ctrl();
        return {m_ibf, m_obf, m_ovf, m_mode, m_dir};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_state(input string req);
        chk(req, cpu_ctrl_rdata, exp_ctrl());
        chk(req, cpu_in_data, m_in);
    endtask

    task automatic ext_write(input logic [7:0] d, input logic cs);
        @(negedge clk);
        ext_data_i = d; ext_cs_n = cs;
        @(negedge clk); ext_wr_n = 1'b0;
        idle(4);
        ext_wr_n = 1'b1;
        idle(4);
        ext_cs_n = 1'b1;
        if (m_mode && !cs) begin
            m_in = d;
            if (m_ibf) m_ovf = 1'b1;
            m_ibf = 1'b1;
        end
        idle(1);
    endtask

    task automatic ext_read(input logic cs);
        @(negedge clk);
        ext_cs_n = cs; ext_rd_n = 1'b0;
        #1;
        chk("R3 oe", {7'b0, ext_data_oe}, {7'b0, m_mode & ~cs});
        if (ext_data_oe) chk("R3 data", ext_data_o, m_out);
        idle(4);
        ext_rd_n = 1'b1;
        #1;
        chk("R3 oe release", {7'b0, ext_data_oe}, 8'h00);
        idle(4);
        ext_cs_n = 1'b1;
        if (m_mode && !cs) m_obf = 1'b0;
        idle(1);
    endtask

    task automatic cpu_ctrl(input logic [7:0] w);
        @(negedge clk);
        cpu_ctrl_we = 1'b1; cpu_ctrl_wdata = w;
        @(negedge clk);
        cpu_ctrl_we = 1'b0;
        m_dir = w[3:0]; m_mode = w[4]; m_ovf = m_ovf & w[5];
    endtask

    task automatic cpu_read_in();
        @(negedge clk);
        chk("R4 in byte", cpu_in_data, m_in);
        cpu_in_re = 1'b1;
        @(negedge clk);
        cpu_in_re = 1'b0;
        m_ibf = 1'b0;
    endtask

    task automatic cpu_write_out(input logic [7:0] w);
        @(negedge clk);
        cpu_out_we = 1'b1; cpu_out_wdata = w;
        @(negedge clk);
        cpu_out_we = 1'b0;
        m_out = w; m_obf = 1'b1;
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        idle(2);
        #1;
        // R1 reset values
        chk("R1 ctrl reset", cpu_ctrl_rdata, 8'b0000_1111);
        chk("R1 oe reset", {7'b0, ext_data_oe}, 8'h00);
        rst_n = 1'b1;
        idle(2);

        // R2 mode clear: strobes ignored
        cpu_write_out(8'h3C);
        ext_write(8'hA5, 1'b0);
        chk_state("R2 write ignored");
        ext_read(1'b0);
        chk_state("R2 read ignored");

        // R9 read-only flag bits
        cpu_ctrl(8'b1101_0110);
        chk_state("R9 ctrl write");

        // R5 deselected write ignored, then real write (R4, R5)
        ext_write(8'h11, 1'b1);
        chk_state("R5 cs high ignored");
        ext_write(8'h5A, 1'b0);
        chk_state("R4 R5 write captured");

        // R7 overrun, write 1 keeps it, write 0 clears it
        ext_write(8'hC3, 1'b0);
        chk_state("R7 overrun set");
        cpu_ctrl(8'b0011_0110);
        chk_state("R7 write one keeps");
        cpu_read_in();
        chk_state("R6 ibf cleared");
        cpu_ctrl(8'b0001_0110);
        chk_state("R7 write zero clears");

        // R8 outgoing-full cleared by external read
        ext_read(1'b0);
        chk_state("R8 obf cleared");
        cpu_write_out(8'h96);
        chk_state("R8 obf set");
        ext_read(1'b1);
        chk_state("R8 cs high keeps obf");
        ext_read(1'b0);
        chk_state("R8 read clears obf");

        // R10 latency through the synchronisers
        @(negedge clk);
        ext_data_i = 8'h77; ext_cs_n = 1'b0;
        @(negedge clk); ext_wr_n = 1'b0;
        idle(4);
        ext_wr_n = 1'b1;
        idle(2);
        chk("R10 not yet at edge two", {7'b0, cpu_ctrl_rdata[7]}, 8'h00);
        idle(1);
        chk("R10 set at edge three", {7'b0, cpu_ctrl_rdata[7]}, 8'h01);
        idle(2);
        ext_cs_n = 1'b1;
        m_in = 8'h77; m_ibf = 1'b1;
        idle(1);
        chk_state("R10 settled");

        // random mix
        for (int i = 0; i < 300; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            case (op)
                0, 1, 2: ext_write(8'($urandom), ($urandom_range(0, 7) == 0));
                3, 4:    ext_read($urandom_range(0, 7) == 0);
                5:       cpu_read_in();
                6, 7:    cpu_write_out(8'($urandom));
                default: cpu_ctrl({3'($urandom), ($urandom_range(0, 9) != 0), 4'($urandom)});
            endcase
            chk_state("R4 R5 R6 R7 R8 R9 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule